// File: doc/BRIEF.md
# Read-Only Status Responder on a Two-Wire Serial Bus

This block is a target device on a two-wire serial bus (I2C) that answers read transactions only. When a master addresses it with the read bit set, it acknowledges the address. It then sends one status byte. It sends that same byte again after every byte the master acknowledges. The master ends the stream by not acknowledging a byte. That missing acknowledge is the end-of-data event: the block releases the data line and clears its sticky power-on flag.

The status byte carries four things:
- the power-on flag;
- a lock flag that rises only after a raw lock input has held through eight reference-tick periods;
- the levels of three digital port inputs;
- a 3-bit converter code.

Both bus lines pass through a two-stage synchroniser into the system clock domain before any edge is detected. The data line is driven only through an open-drain pull-low enable, and that enable changes only while the clock line is low. All pins are plain control and status signals; there is no streaming handshake at the edge of the block.

Top module: `i2c_status_slave`

## Requirements
- R1: The block acknowledges (pulls SDA low in the ninth clock) an address byte equal to 1,1,0,0,0,sel_addr[1],sel_addr[0],1, listed MSB first.
- R2: An address byte with a different select field, or with bit 0 (read/write) equal to 0, gets no acknowledge, and SDA stays released for the rest of that transfer.
- R3: The status byte, MSB first, is {por, lock flag, port_in[2], port_in[1], port_in[0], level_code[2:0]}.
- R4: While the master acknowledges each status byte, the block sends another status byte. This continues for any number of bytes.
- R5: A master not-acknowledge after a status byte releases SDA and clears the power-on flag.
- R6: The power-on flag is 1 after reset. It is set to 1 whenever supply_low is high. Only R5 clears it: a STOP without a prior not-acknowledge leaves it set.
- R7: The lock flag becomes 1 on the eighth ref_tick counted while lock_raw stays high, and not before.
- R8: When lock_raw goes low, the lock flag is 0 from the next cycle on. The tick count restarts from zero.
- R9: The status byte is captured when its first bit is launched. Input changes during a byte show up only in the next byte.
- R10: A START or a STOP at any point returns the block to idle. A START also begins a new address phase.
- R11: sda_drive_low changes only while the synchronised SCL is low, except when a START or STOP aborts the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| sel_addr | input | 2 | Address select bits, placed at address bits 2:1 |
| lock_raw | input | 1 | Unqualified phase-lock indication |
| ref_tick | input | 1 | One-cycle strobe per reference period |
| port_in | input | 3 | Digital port input levels |
| level_code | input | 3 | Converter level code |
| supply_low | input | 1 | Supply-dropped indication, sets the power-on flag |

## Verification
The hardest case to reach from the ports is a STOP or repeated START after an acknowledged address but before any status bit has been clocked out. The bus only allows this if the first status bit is released, which holds here because the power-on flag is 1 at that moment. The bench therefore pulses supply_low first, then opens a read and aborts it once the slave has acknowledged. A later read must still report the power-on flag set. Lock qualification is driven by exact counts of ref_tick pulses, 7 and then 8, around a lock_raw drop. Each result is observed through a complete bus read.

// File: rtl/i2c_status_pkg.sv
package i2c_status_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_TX,
    ST_MACK
  } rd_state_t;

  localparam int BYTE_BITS = 8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier #(
  parameter int PERIODS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_raw,
  input  logic ref_tick,
  output logic lock_ok
);
  localparam int CW = $clog2(PERIODS + 1);
  localparam logic [CW-1:0] FULL = CW'(PERIODS);
  localparam logic [CW-1:0] LAST = CW'(PERIODS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      lock_ok <= 1'b0;
    end else if (!lock_raw) begin
      cnt     <= '0;
      lock_ok <= 1'b0;
    end else if (ref_tick && cnt != FULL) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) lock_ok <= 1'b1;
    end
  end
endmodule

// File: rtl/por_keeper.sv
module por_keeper (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low,
  input  logic eod,
  output logic por
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          por <= 1'b1;
    else if (supply_low) por <= 1'b1;
    else if (eod)        por <= 1'b0;
  end
endmodule

// File: rtl/i2c_read_fsm.sv
module i2c_read_fsm
  import i2c_status_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b11000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [1:0] sel_addr,
  input  logic [7:0] status,
  output logic       sda_drive_low,
  output logic       eod,
  output logic       busy
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_BITS - 1);

  rd_state_t        st;
  logic [CNT_W-1:0] bitcnt;
  logic [7:0]       sh;
  logic [7:0]       my_addr;

  assign my_addr = {ADDR_HI, sel_addr, 1'b1};
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      bitcnt        <= '0;
      sh            <= '0;
      sda_drive_low <= 1'b0;
      eod           <= 1'b0;
    end else begin
      eod <= 1'b0;
      if (start_ev) begin
        st            <= ST_ADDR;
        bitcnt        <= '0;
        sda_drive_low <= 1'b0;
      end else if (stop_ev) begin
        st            <= ST_IDLE;
        sda_drive_low <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: begin
            if (scl_rise && bitcnt != FULL_CNT) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == FULL_CNT) begin
              if (sh == my_addr) begin
                st            <= ST_AACK;
                sda_drive_low <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              sh            <= status;
              sda_drive_low <= ~status[7];
              bitcnt        <= '0;
              st            <= ST_TX;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == LAST_CNT) begin
                sda_drive_low <= 1'b0;
                st            <= ST_MACK;
              end else begin
                sh            <= {sh[6:0], 1'b0};
                sda_drive_low <= ~sh[6];
                bitcnt        <= bitcnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (sda_s) begin
                eod <= 1'b1;
                st  <= ST_IDLE;
              end else begin
                st <= ST_AACK;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_status_slave.sv
module i2c_status_slave #(
  parameter int         SYNC_STAGES  = 2,
  parameter int         LOCK_PERIODS = 8,
  parameter logic [4:0] ADDR_HI      = 5'b11000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_drive_low,
  input  logic [1:0] sel_addr,
  input  logic       lock_raw,
  input  logic       ref_tick,
  input  logic [2:0] port_in,
  input  logic [2:0] level_code,
  input  logic       supply_low
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic lock_ok, por, eod, busy;
  logic [7:0] status;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  lock_qualifier #(.PERIODS(LOCK_PERIODS)) u_lock (
    .clk(clk), .rst_n(rst_n), .lock_raw(lock_raw), .ref_tick(ref_tick),
    .lock_ok(lock_ok)
  );

  por_keeper u_por (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .eod(eod), .por(por)
  );

  assign status = {por, lock_ok, port_in, level_code};

  i2c_read_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .sel_addr(sel_addr), .status(status), .sda_drive_low(sda_drive_low),
    .eod(eod), .busy(busy)
  );
endmodule

// File: rtl/i2c_status_slave_chk.sv
module i2c_status_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_ev,
  input logic stop_ev,
  input logic sda_drive_low,
  input logic lock_raw,
  input logic ref_tick,
  input logic lock_ok,
  input logic supply_low,
  input logic por,
  input logic eod,
  input logic busy
);
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_drive_low) && !$past(start_ev) && !$past(stop_ev)) |-> $past(!scl_s))
    else $error("R11 SDA drive changed while SCL high");

  p_lock_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_raw |=> !lock_ok)
    else $error("R8 lock flag survived lock loss");

  p_lock_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_ok) |-> $past(ref_tick && lock_raw))
    else $error("R7 lock flag rose without a counted tick");

  p_por_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> por)
    else $error("R6 supply_low did not set por");

  p_por_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por) |-> $past(eod))
    else $error("R5 por cleared without end-of-data");

  p_drive_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drive_low |-> busy)
    else $error("R2 SDA driven while idle");

  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!busy && !sda_drive_low))
    else $error("R10 STOP did not return to idle");
endmodule

bind i2c_status_slave i2c_status_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_ev(start_ev),
  .stop_ev(stop_ev), .sda_drive_low(sda_drive_low), .lock_raw(lock_raw),
  .ref_tick(ref_tick), .lock_ok(lock_ok), .supply_low(supply_low),
  .por(por), .eod(eod), .busy(busy)
);

// File: tb/i2c_status_slave_bench.sv
module i2c_status_slave_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_drive_low;
  logic sda;
  logic [1:0] sel_addr = 2'b10;
  logic lock_raw = 1'b0;
  logic ref_tick = 1'b0;
  logic [2:0] port_in = 3'b101;
  logic [2:0] level_code = 3'b010;
  logic supply_low = 1'b0;

  int total = 0;
  int bad = 0;
  int hi_changes = 0;
  int cycles = 0;
  logic prev_oe = 1'b0;
  logic prev_scl = 1'b1;

  always #10 clk = ~clk;

  assign sda = ~(m_low | sda_drive_low);

  i2c_status_slave u_i2c_status_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .sda_drive_low(sda_drive_low), .sel_addr(sel_addr), .lock_raw(lock_raw),
    .ref_tick(ref_tick), .port_in(port_in), .level_code(level_code),
    .supply_low(supply_low)
  );

  // R11 monitor: the drive enable must not move while SCL is held high
  always @(posedge clk) begin
    if (rst_n && prev_scl && scl && (prev_oe != sda_drive_low)) hi_changes++;
    prev_oe  <= sda_drive_low;
    prev_scl <= scl;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; tq();
    scl = 1'b1; tq();
    m_low = 1'b1; tq();
    scl = 1'b0; tq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tq();
    scl = 1'b1; tq();
    m_low = 1'b0; tq();
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; tq();
    scl = 1'b1; tq(); tq();
    scl = 1'b0; tq();
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; tq();
    scl = 1'b1; tq();
    b = sda; tq();
    scl = 1'b0; tq();
  endtask

  task automatic open_read(input logic [7:0] addr, output logic ack_low);
    bus_start();
    for (int i = 7; i >= 0; i--) put_bit(addr[i]);
    get_bit(ack_low);
  endtask

  task automatic get_byte(input logic master_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) get_bit(b[i]);
    put_bit(~master_ack);
    m_low = 1'b0;
  endtask

  function automatic logic [7:0] rd_addr(input logic [1:0] s);
    return {5'b11000, s, 1'b1};
  endfunction

  task automatic t_reset_state();
    check("R6 reset drive released", {7'd0, sda_drive_low}, 8'd0);
  endtask

  task automatic t_first_read();
    logic a; logic [7:0] b;
    open_read(rd_addr(2'b10), a);
    check("R1 address ack", {7'd0, a}, 8'd0);
    get_byte(1'b0, b);
    check("R3 R6 status with por set", b, 8'b1010_1010);
    tq();
    check("R5 SDA released after nack", {7'd0, sda_drive_low}, 8'd0);
    bus_stop();
    open_read(rd_addr(2'b10), a);
    get_byte(1'b0, b);
    bus_stop();
    check("R5 por cleared by nack", b, 8'b0010_1010);
  endtask

  task automatic t_repeat();
    logic a; logic [7:0] b;
    port_in = 3'b011; level_code = 3'b110;
    open_read(rd_addr(2'b10), a);
    for (int k = 0; k < 3; k++) begin
      get_byte(k != 2, b);
      check("R4 repeated status byte", b, 8'b0001_1110);
    end
    bus_stop();
  endtask

  task automatic t_sample();
    logic a; logic [7:0] b;
    port_in = 3'b100; level_code = 3'b001;
    open_read(rd_addr(2'b10), a);
    get_bit(b[7]);
    port_in = 3'b010; level_code = 3'b111;
    for (int i = 6; i >= 0; i--) get_bit(b[i]);
    put_bit(1'b0);
    m_low = 1'b0;
    check("R9 byte held while shifting", b, 8'b0010_0001);
    get_byte(1'b0, b);
    check("R9 next byte sees new inputs", b, 8'b0001_0111);
    bus_stop();
  endtask

  task automatic t_addr_miss();
    logic a; logic [7:0] b;
    open_read(rd_addr(2'b01), a);
    check("R2 wrong select no ack", {7'd0, a}, 8'd1);
    get_bit(b[0]);
    check("R2 SDA stays released", {7'd0, b[0]}, 8'd1);
    bus_stop();
    open_read({5'b11000, 2'b10, 1'b0}, a);
    check("R2 write bit no ack", {7'd0, a}, 8'd1);
    bus_stop();
    sel_addr = 2'b01;
    open_read(rd_addr(2'b01), a);
    check("R1 other select acked", {7'd0, a}, 8'd0);
    get_byte(1'b0, b);
    bus_stop();
    sel_addr = 2'b10;
  endtask

  task automatic t_supply_abort();
    logic a; logic [7:0] b;
    port_in = 3'b000; level_code = 3'b000;
    @(negedge clk); supply_low = 1'b1;
    @(negedge clk); supply_low = 1'b0;
    open_read(rd_addr(2'b10), a);
    check("R10 ack before stop abort", {7'd0, a}, 8'd0);
    bus_stop();
    check("R10 idle after stop", {7'd0, sda_drive_low}, 8'd0);
    open_read(rd_addr(2'b10), a);
    m_low = 1'b0; tq();
    open_read(rd_addr(2'b10), a);
    check("R10 repeated start new address", {7'd0, a}, 8'd0);
    get_byte(1'b0, b);
    bus_stop();
    check("R6 por kept across stop", b, 8'b1000_0000);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic read_one(output logic [7:0] b);
    logic a;
    open_read(rd_addr(2'b10), a);
    get_byte(1'b0, b);
    bus_stop();
  endtask

  task automatic t_lock();
    logic [7:0] b;
    port_in = 3'b000; level_code = 3'b000;
    @(negedge clk); lock_raw = 1'b1;
    ticks(7);
    read_one(b);
    check("R7 no lock after 7 ticks", b, 8'b0000_0000);
    ticks(1);
    read_one(b);
    check("R7 lock after 8 ticks", b, 8'b0100_0000);
    @(negedge clk); lock_raw = 1'b0;
    @(negedge clk); lock_raw = 1'b1;
    read_one(b);
    check("R8 lock cleared by drop", b, 8'b0000_0000);
    ticks(7);
    read_one(b);
    check("R8 count restarted", b, 8'b0000_0000);
    ticks(1);
    read_one(b);
    check("R7 relock after 8 ticks", b, 8'b0100_0000);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset_state();
    t_first_read();
    t_repeat();
    t_sample();
    t_addr_miss();
    t_supply_abort();
    t_lock();
    check("R11 no drive change with SCL high", 8'(hi_changes), 8'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=finish", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule